// File: doc/BRIEF.md
# Nanosecond to Clock-Count Converter

This block turns interface timing figures given in nanoseconds into whole bus-clock counts for a bus frequency that is chosen at run time in MHz. Two devices share one channel. For each device the caller supplies an address setup time, an active (data strobe) time and a total cycle time. The block derives the recovery time as the cycle time less the setup and active times. Each of the three times becomes a clock count that is rounded up. Each count is then held inside the range the timing hardware can program, and the counts are packed into the byte and field codes that the timing registers take.

A single shared multiplier and a single restoring divider work serially through the six conversions. The caller pulses `start` while the block is idle. All inputs are captured on that edge, and `done` pulses once all results are in place. A device flagged as absent receives the smallest legal timing, whatever times were supplied for it. Choosing a transfer mode and looking up its times happen outside this block.

Top module: `nsclk_conv`

## Requirements
- R1: A time t (ns) at frequency f (MHz) converts to the count floor((t*f + 999) / 1000), so any fractional clock rounds up and an exact multiple of 1000 does not.
- R2: The recovery time is cyc_ns - su_ns - act_ns when that is positive, and 0 otherwise. It is converted as in R1.
- R3: The setup count on `setup_clk` is clamped into 1..4.
- R4: The data count on `data_clk` is clamped into 1..16.
- R5: The recovery count on `rec_clk` is clamped into 2..17.
- R6: A device whose `dev_absent` bit was 1 at start gets setup 1, data 1 and recovery 2.
- R7: `cyc_code[d]` holds (data-1) in bits 7:4 and (recovery-2) in bits 3:0.
- R8: `setup_code` equals the larger of the two devices' setup counts minus 1. An absent device contributes a setup count of 1.
- R9: A start while idle captures every input and raises `busy` on the next cycle. `done` is high for exactly one cycle, in the same cycle that `busy` falls. A start while busy is ignored and produces no extra run.
- R10: After reset, `busy`, `done` and all result outputs are 0.
- R11: The result outputs change only in the cycle where `done` is high. They keep their values during a run and between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion (honoured only when idle) |
| dev_absent | input | 2 | Per device: 1 forces minimum timing |
| su_ns | input | 2x10 | Per device address setup time, ns |
| act_ns | input | 2x10 | Per device active strobe time, ns |
| cyc_ns | input | 2x10 | Per device total cycle time, ns |
| mhz | input | 7 | Bus frequency, MHz |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse, results updated |
| setup_clk | output | 2x3 | Per device clamped setup count |
| data_clk | output | 2x5 | Per device clamped data count |
| rec_clk | output | 2x5 | Per device clamped recovery count |
| cyc_code | output | 2x8 | Per device packed cycle byte |
| setup_code | output | 2 | Shared setup field |

## Verification
On every cycle the assertions check the handshake: `done` lasts one cycle, `busy` falls only with `done`, and outputs stay stable outside `done`. In each `done` cycle they also check the clamp ranges, the minimum values for absent devices, and that the packed byte and the shared setup field agree with the counts beside them. The rounding itself can only be shown by the bench's scenarios. These cover the exact ceiling value, the behaviour at exact multiples, saturation of a negative recovery, frequency zero, the largest inputs, and a start that arrives mid-run. The bench compares each of these against its own arithmetic.

// File: rtl/nsclk_pkg.sv
package nsclk_pkg;

  // result field widths set by the timing register encodings
  localparam int SU_W = 3;
  localparam int DC_W = 5;
  localparam int RC_W = 5;
  localparam int SC_W = 2;

  // programmable ranges of each count
  localparam int SU_LO = 1;
  localparam int SU_HI = 4;
  localparam int DC_LO = 1;
  localparam int DC_HI = 16;
  localparam int RC_LO = 2;
  localparam int RC_HI = 17;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_MUL  = 2'd1,
    S_WMUL = 2'd2,
    S_WDIV = 2'd3
  } seq_st_e;

  function automatic logic [31:0] clamp_f(input logic [31:0] v,
                                          input logic [31:0] lo,
                                          input logic [31:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [7:0] pack_cycle_f(input logic [DC_W-1:0] dcnt,
                                              input logic [RC_W-1:0] rcnt);
    return {4'(dcnt - DC_W'(1)), 4'(rcnt - RC_W'(2))};
  endfunction

  function automatic logic [SC_W-1:0] setup_code_f(input logic [SU_W-1:0] a,
                                                   input logic [SU_W-1:0] b);
    logic [SU_W-1:0] m;
    m = (a > b) ? a : b;
    return SC_W'(m - SU_W'(1));
  endfunction

endpackage

// File: rtl/nsclk_mul.sv
module nsclk_mul #(
  parameter int AW = 10,
  parameter int BW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic             done,
  output logic [AW+BW-1:0] prod
);
  localparam int PW = AW + BW;
  localparam int CW = $clog2(BW + 1);

  logic [PW-1:0] acc;
  logic [PW-1:0] mcand;
  logic [BW-1:0] mplier;
  logic [CW-1:0] cnt;
  logic          run;

  // shift-add: one multiplier bit per cycle, BW cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc    <= '0;
        mcand  <= PW'(a);
        mplier <= b;
        cnt    <= CW'(BW);
        run    <= 1'b1;
      end else if (run) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;

endmodule

// File: rtl/nsclk_div.sv
module nsclk_div #(
  parameter int NW      = 18,
  parameter int DIVISOR = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int RW  = $clog2(DIVISOR) + 1;
  localparam int RMW = RW - 1;
  localparam int CW  = $clog2(NW + 1);

  logic [RMW-1:0] rem;
  logic [NW-1:0]  sh;
  logic [NW-1:0]  q;
  logic [CW-1:0]  cnt;
  logic           run;
  logic [RW-1:0]  trial;
  logic           ge;

  assign trial = {rem, sh[NW-1]};
  assign ge    = (trial >= RW'(DIVISOR));

  // restoring division: one quotient bit per cycle, NW cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      sh   <= '0;
      q    <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0;
        sh  <= num;
        q   <= '0;
        cnt <= CW'(NW);
        run <= 1'b1;
      end else if (run) begin
        rem <= ge ? RMW'(trial - RW'(DIVISOR)) : RMW'(trial);
        sh  <= sh << 1;
        q   <= {q[NW-2:0], ge};
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = q;

endmodule

// File: rtl/nsclk_seq.sv
module nsclk_seq
  import nsclk_pkg::*;
#(
  parameter int TW      = 10,
  parameter int FW      = 7,
  parameter int NW      = TW + FW + 1,
  parameter int DIVISOR = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [1:0][TW-1:0]       su_ns,
  input  logic [1:0][TW-1:0]       act_ns,
  input  logic [1:0][TW-1:0]       cyc_ns,
  input  logic [FW-1:0]            mhz,
  output logic                     mul_start,
  output logic [TW-1:0]            mul_a,
  output logic [FW-1:0]            mul_b,
  input  logic                     mul_done,
  input  logic [TW+FW-1:0]         mul_p,
  output logic                     div_start,
  output logic [NW-1:0]            div_n,
  input  logic                     div_done,
  input  logic [NW-1:0]            div_q,
  output logic                     fin,
  output logic [1:0][2:0][NW-1:0]  raw
);

  // remaining part of the cycle, floored at zero
  function automatic logic [TW-1:0] rec_ns_f(input logic [TW-1:0] s,
                                             input logic [TW-1:0] a,
                                             input logic [TW-1:0] c);
    logic [TW:0] used;
    used = {1'b0, s} + {1'b0, a};
    if ({1'b0, c} > used) return TW'({1'b0, c} - used);
    return '0;
  endfunction

  seq_st_e                   st;
  logic [1:0][2:0][TW-1:0]   ns_q;
  logic [FW-1:0]             mhz_q;
  logic                      dev;
  logic [1:0]                fld;
  logic                      last;

  assign last      = dev && (fld == 2'd2);
  assign mul_start = (st == S_MUL);
  assign mul_a     = ns_q[dev][fld];
  assign mul_b     = mhz_q;
  assign div_start = (st == S_WMUL) && mul_done;
  assign div_n     = NW'(mul_p) + NW'(DIVISOR - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ns_q  <= '0;
      mhz_q <= '0;
      dev   <= 1'b0;
      fld   <= 2'd0;
      fin   <= 1'b0;
      raw   <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go) begin
            for (int d = 0; d < 2; d++) begin
              ns_q[d][0] <= su_ns[d];
              ns_q[d][1] <= act_ns[d];
              ns_q[d][2] <= rec_ns_f(su_ns[d], act_ns[d], cyc_ns[d]);
            end
            mhz_q <= mhz;
            dev   <= 1'b0;
            fld   <= 2'd0;
            st    <= S_MUL;
          end
        end
        S_MUL: st <= S_WMUL;
        S_WMUL: begin
          if (mul_done) st <= S_WDIV;
        end
        S_WDIV: begin
          if (div_done) begin
            raw[dev][fld] <= div_q;
            if (last) begin
              fin <= 1'b1;
              st  <= S_IDLE;
            end else begin
              if (fld == 2'd2) begin
                fld <= 2'd0;
                dev <= 1'b1;
              end else begin
                fld <= fld + 2'd1;
              end
              st <= S_MUL;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nsclk_conv.sv
module nsclk_conv
  import nsclk_pkg::*;
#(
  parameter int TW      = 10,
  parameter int FW      = 7,
  parameter int DIVISOR = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            dev_absent,
  input  logic [1:0][TW-1:0]    su_ns,
  input  logic [1:0][TW-1:0]    act_ns,
  input  logic [1:0][TW-1:0]    cyc_ns,
  input  logic [FW-1:0]         mhz,
  output logic                  busy,
  output logic                  done,
  output logic [1:0][SU_W-1:0]  setup_clk,
  output logic [1:0][DC_W-1:0]  data_clk,
  output logic [1:0][RC_W-1:0]  rec_clk,
  output logic [1:0][7:0]       cyc_code,
  output logic [SC_W-1:0]       setup_code
);
  localparam int NW = TW + FW + 1;

  logic                     go;
  logic [1:0]               abs_q;
  logic                     mul_start, mul_done, div_start, div_done, fin;
  logic [TW-1:0]            mul_a;
  logic [FW-1:0]            mul_b;
  logic [TW+FW-1:0]         mul_p;
  logic [NW-1:0]            div_n, div_q;
  logic [1:0][2:0][NW-1:0]  raw;

  logic [1:0][SU_W-1:0]     nxt_su;
  logic [1:0][DC_W-1:0]     nxt_dc;
  logic [1:0][RC_W-1:0]     nxt_rc;
  logic [1:0][7:0]          nxt_cyc;
  logic [SC_W-1:0]          nxt_sc;

  assign go = start && !busy;

  nsclk_seq #(.TW(TW), .FW(FW), .NW(NW), .DIVISOR(DIVISOR)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go),
    .su_ns(su_ns), .act_ns(act_ns), .cyc_ns(cyc_ns), .mhz(mhz),
    .mul_start(mul_start), .mul_a(mul_a), .mul_b(mul_b),
    .mul_done(mul_done), .mul_p(mul_p),
    .div_start(div_start), .div_n(div_n),
    .div_done(div_done), .div_q(div_q),
    .fin(fin), .raw(raw)
  );

  nsclk_mul #(.AW(TW), .BW(FW)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(mul_start),
    .a(mul_a), .b(mul_b), .done(mul_done), .prod(mul_p)
  );

  nsclk_div #(.NW(NW), .DIVISOR(DIVISOR)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(div_n), .done(div_done), .quo(div_q)
  );

  // clamp and pack per device
  for (genvar d = 0; d < 2; d++) begin : g_dev
    always_comb begin
      if (abs_q[d]) begin
        nxt_su[d] = SU_W'(SU_LO);
        nxt_dc[d] = DC_W'(DC_LO);
        nxt_rc[d] = RC_W'(RC_LO);
      end else begin
        nxt_su[d] = SU_W'(clamp_f(32'(raw[d][0]), SU_LO, SU_HI));
        nxt_dc[d] = DC_W'(clamp_f(32'(raw[d][1]), DC_LO, DC_HI));
        nxt_rc[d] = RC_W'(clamp_f(32'(raw[d][2]), RC_LO, RC_HI));
      end
      nxt_cyc[d] = pack_cycle_f(nxt_dc[d], nxt_rc[d]);
    end
  end

  assign nxt_sc = setup_code_f(nxt_su[0], nxt_su[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      abs_q      <= '0;
      setup_clk  <= '0;
      data_clk   <= '0;
      rec_clk    <= '0;
      cyc_code   <= '0;
      setup_code <= '0;
    end else begin
      done <= fin;
      if (go) begin
        busy  <= 1'b1;
        abs_q <= dev_absent;
      end else if (fin) begin
        busy <= 1'b0;
      end
      if (fin) begin
        setup_clk  <= nxt_su;
        data_clk   <= nxt_dc;
        rec_clk    <= nxt_rc;
        cyc_code   <= nxt_cyc;
        setup_code <= nxt_sc;
      end
    end
  end

endmodule

// File: rtl/nsclk_conv_chk.sv
module nsclk_conv_chk
  import nsclk_pkg::*;
#(
  parameter int TW = 10,
  parameter int FW = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  done,
  input logic [1:0]            abs_q,
  input logic [1:0][SU_W-1:0]  setup_clk,
  input logic [1:0][DC_W-1:0]  data_clk,
  input logic [1:0][RC_W-1:0]  rec_clk,
  input logic [1:0][7:0]       cyc_code,
  input logic [SC_W-1:0]       setup_code
);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(cyc_code) && $stable(setup_code) && $stable(setup_clk)
               && $stable(data_clk) && $stable(rec_clk)));

  p_setup_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (setup_code == SC_W'(((setup_clk[0] > setup_clk[1]) ?
                                   setup_clk[0] : setup_clk[1]) - SU_W'(1))));

  for (genvar d = 0; d < 2; d++) begin : g_chk
    p_setup_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (setup_clk[d] >= SU_W'(SU_LO) && setup_clk[d] <= SU_W'(SU_HI)));

    p_data_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (data_clk[d] >= DC_W'(DC_LO) && data_clk[d] <= DC_W'(DC_HI)));

    p_rec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rec_clk[d] >= RC_W'(RC_LO) && rec_clk[d] <= RC_W'(RC_HI)));

    p_absent_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && abs_q[d]) |-> (setup_clk[d] == SU_W'(1) && data_clk[d] == DC_W'(1)
                              && rec_clk[d] == RC_W'(2)));

    p_cyc_pack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cyc_code[d][7:4] == 4'(data_clk[d] - DC_W'(1))
                && cyc_code[d][3:0] == 4'(rec_clk[d] - RC_W'(2))));
  end

endmodule

bind nsclk_conv nsclk_conv_chk #(.TW(TW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .abs_q(abs_q),
  .setup_clk(setup_clk), .data_clk(data_clk), .rec_clk(rec_clk),
  .cyc_code(cyc_code), .setup_code(setup_code)
);

// File: tb/nsclk_conv_bench.sv
module nsclk_conv_bench;
  localparam int TW = 10;
  localparam int FW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_n;
  logic               start;
  logic [1:0]         dev_absent;
  logic [1:0][TW-1:0] su_ns, act_ns, cyc_ns;
  logic [FW-1:0]      mhz;
  logic               busy, done;
  logic [1:0][2:0]    setup_clk;
  logic [1:0][4:0]    data_clk, rec_clk;
  logic [1:0][7:0]    cyc_code;
  logic [1:0]         setup_code;

  nsclk_conv u_nsclk_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_absent(dev_absent),
    .su_ns(su_ns), .act_ns(act_ns), .cyc_ns(cyc_ns), .mhz(mhz),
    .busy(busy), .done(done), .setup_clk(setup_clk), .data_clk(data_clk),
    .rec_clk(rec_clk), .cyc_code(cyc_code), .setup_code(setup_code)
  );

  int n_chk = 0;
  int n_fail = 0;
  int e_su[2], e_dc[2], e_rc[2], e_cyc[2], e_sc;

  function automatic int ceil_clk(int t, int f);
    return (t * f + 999) / 1000;
  endfunction

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_dev(input int d, input bit ab, input int s, input int a, input int c);
    dev_absent[d] = ab;
    su_ns[d]  = TW'(s);
    act_ns[d] = TW'(a);
    cyc_ns[d] = TW'(c);
  endtask

  task automatic compute_exp();
    for (int d = 0; d < 2; d++) begin
      int s, a, c, r;
      s = int'(su_ns[d]); a = int'(act_ns[d]); c = int'(cyc_ns[d]);
      r = (c > s + a) ? c - s - a : 0;  // R2 floor at zero
      if (dev_absent[d]) begin
        e_su[d] = 1; e_dc[d] = 1; e_rc[d] = 2;
      end else begin
        e_su[d] = clampi(ceil_clk(s, int'(mhz)), 1, 4);
        e_dc[d] = clampi(ceil_clk(a, int'(mhz)), 1, 16);
        e_rc[d] = clampi(ceil_clk(r, int'(mhz)), 2, 17);
      end
      e_cyc[d] = ((e_dc[d] - 1) << 4) | (e_rc[d] - 2);
    end
    e_sc = ((e_su[0] > e_su[1]) ? e_su[0] : e_su[1]) - 1;
  endtask

  task automatic launch();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", int'(busy), 1);
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        break;
      end
    end
    if (!ok) begin
      n_chk++; n_fail++;
      $display("FAIL R9 done not seen actual=0 expected=1");
    end
  endtask

  task automatic check_results(input string tag);
    for (int d = 0; d < 2; d++) begin
      chk({tag, " R3 setup count"}, int'(setup_clk[d]), e_su[d]);
      chk({tag, " R1 R4 data count"}, int'(data_clk[d]), e_dc[d]);
      chk({tag, " R2 R5 recovery count"}, int'(rec_clk[d]), e_rc[d]);
      chk({tag, " R7 cycle byte"}, int'(cyc_code[d]), e_cyc[d]);
    end
    chk({tag, " R8 setup field"}, int'(setup_code), e_sc);
  endtask

  task automatic run_case(input string tag, input bit hold_chk);
    bit ok;
    int p_cyc0, p_sc;
    p_cyc0 = e_cyc[0];
    p_sc   = e_sc;
    compute_exp();
    launch();
    if (hold_chk) begin
      repeat (40) @(negedge clk);
      chk({tag, " R11 held during run"}, int'(cyc_code[0]), p_cyc0);
      chk({tag, " R11 field held during run"}, int'(setup_code), p_sc);
    end
    wait_done(ok);
    if (ok) check_results(tag);
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, int'(done), 0);
    chk({tag, " R9 idle after done"}, int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ok;
    int seen;
    rst_n = 1'b0; start = 1'b0; dev_absent = '0;
    su_ns = '0; act_ns = '0; cyc_ns = '0; mhz = '0;
    e_su = '{0, 0}; e_dc = '{0, 0}; e_rc = '{0, 0}; e_cyc = '{0, 0}; e_sc = 0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 busy at reset", int'(busy), 0);
    chk("R10 done at reset", int'(done), 0);
    chk("R10 cycle byte at reset", int'(cyc_code), 0);
    chk("R10 setup field at reset", int'(setup_code), 0);
    chk("R10 counts at reset", int'(data_clk) + int'(rec_clk) + int'(setup_clk), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 rounding: 80 ns at 40 MHz -> 4 clocks
    mhz = 7'd40;
    set_dev(0, 0, 70, 80, 600);
    set_dev(1, 0, 25, 290, 383);
    run_case("typical", 1'b0);
    chk("R1 80ns at 40MHz rounds up to 4", int'(data_clk[0]), 4);

    // R1 exact multiple: 125 ns at 40 MHz -> 5, no extra clock
    set_dev(0, 0, 25, 125, 300);
    set_dev(1, 0, 50, 125, 400);
    run_case("exact", 1'b0);
    chk("R1 exact multiple not rounded up", int'(data_clk[0]), 5);

    // R2 negative recovery saturates, clamped to 2 (R5); upper clamps R3 R4
    mhz = 7'd127;
    set_dev(0, 0, 1023, 1023, 1023);
    set_dev(1, 0, 0, 0, 1023);
    run_case("limits", 1'b0);
    chk("R2 negative recovery gives 2", int'(rec_clk[0]), 2);
    chk("R5 recovery upper clamp 17", int'(rec_clk[1]), 17);
    chk("R3 setup upper clamp 4", int'(setup_clk[0]), 4);

    // frequency zero: everything at lower bounds
    mhz = 7'd0;
    set_dev(0, 0, 500, 500, 1000);
    set_dev(1, 0, 10, 10, 100);
    run_case("zero freq", 1'b0);

    // R6 absent devices
    mhz = 7'd100;
    set_dev(0, 0, 100, 300, 900);
    set_dev(1, 1, 900, 900, 1023);
    run_case("R6 one absent", 1'b1);
    chk("R6 absent data minimum", int'(data_clk[1]), 1);
    set_dev(0, 1, 900, 900, 1023);
    run_case("R6 both absent", 1'b1);
    chk("R6 both absent setup field", int'(setup_code), 0);

    // R9 start while busy is ignored
    mhz = 7'd33;
    set_dev(0, 0, 70, 165, 383);
    set_dev(1, 0, 30, 125, 240);
    compute_exp();
    launch();
    repeat (30) @(negedge clk);
    mhz = 7'd90;
    set_dev(0, 1, 5, 5, 5);
    set_dev(1, 0, 900, 900, 1000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (ok) check_results("R9 busy start ignored");
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk("R9 no second run from ignored start", seen, 0);

    // random mix
    void'($urandom(32'd20240917));
    for (int k = 0; k < 200; k++) begin
      mhz = FW'($urandom % 128);
      for (int d = 0; d < 2; d++) begin
        int s, a, c;
        s = int'($urandom % 200);
        a = int'($urandom % 700);
        c = ($urandom % 4 == 0) ? int'($urandom % 1024) : s + a + int'($urandom % 400);
        if (c > 1023) c = 1023;
        set_dev(d, ($urandom % 8) == 0, s, a, c);
      end
      run_case("random", (k % 4) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule